// File: doc/BRIEF.md
# Indexed Register Window Decoder

This block decodes a 32-byte host I/O region in which one 16-byte data window is shared among several unrelated internal resources. The host first stores a selector value in an index register. Every later access to the window then goes to the resource that the stored value names. The index register holds its value between accesses, so the target of a window access depends on an earlier write.

There are five resources: two packet-controller channels, a byte FIFO that belongs to a line-interface controller, and the lower and upper banks of that controller's register map. For each window access the decoder raises one qualified strobe to the selected target and passes it the 4-bit offset within the window. It returns the target's read data in the same cycle. The targets are simple stub models that give the decoder observable state. Each packet channel has a 32-bit data queue and a control word. The line FIFO is a byte queue. Each register bank holds sixteen byte registers.

Top module: `idxwin_decoder`

## Requirements
- R1: The index register sits at region offset 0x04 and resets to 0x00. A read of offset 0x04 returns the stored value in bits 7:0, with bits 31:8 at zero.
- R2: A write to offset 0x04 stores host write-data bits 7:0 in the index register. No other access changes the index register.
- R3: Index 0x00 selects packet channel 1 and index 0x01 selects packet channel 2. Window offset 0x4 is the 32-bit control word of the selected channel. It resets to zero and each channel keeps its own copy.
- R4: Window offset 0x0 of a packet channel is a 32-bit data queue with CH_DEPTH entries (default 4). A write appends an entry, and a write to a full queue is dropped. A read returns and removes the oldest entry, and a read of an empty queue returns zero. All other offsets of a channel read zero and ignore writes.
- R5: Index 0x02 selects the line-controller byte FIFO, which holds LF_DEPTH entries (default 8). A write to window offset 0 appends write-data bits 7:0, and a write to a full FIFO is dropped. Successive reads of offset 0 return the bytes in order in bits 7:0, with zero in the upper bits. An empty FIFO reads zero, and the other offsets read zero.
- R6: Index 0x04 selects the low register bank and index 0x06 selects the high bank. Each bank has sixteen byte registers, addressed by the window offset and reset to zero. Line-controller register numbers above 0x2F are reached through the high bank and the rest through the low bank, in both cases at window offset equal to the low 4 bits of the register number.
- R7: When the stored index is any value other than 0x00, 0x01, 0x02, 0x04 or 0x06, a window read returns 0xFFFFFFFF. A window write in that state changes no target, and no target strobe is raised.
- R8: The one-hot strobe vector `tgt_stb` has bit 0 for channel 1, bit 1 for channel 2, bit 2 for the line FIFO, bit 3 for the low bank and bit 4 for the high bank. During a window access with a defined index, exactly one bit is high, in the same cycle as the access, and `tgt_off` equals address bits 3:0. Otherwise the vector is all zero.
- R9: Region offsets that are neither 0x04 nor in the window 0x10 to 0x1F read zero, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_en | input | 1 | Host access valid this cycle |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 5 | Byte offset within the 32-byte region |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data, valid in the cycle of a read access |
| tgt_stb | output | 5 | One-hot target strobe for the access |
| tgt_off | output | 4 | Window offset forwarded to the target |

## Verification
Directed sequences first program each defined index value and then read back control words, queue contents and bank registers. This shows that the window follows the stored index and not the current address alone, and that the two channels and the two banks do not alias one another. Underflow and overflow of both queues are driven directly to separate dropped writes and empty reads from normal traffic. An undefined index is selected and then written through. The affected locations are then read back under a valid index to show that nothing changed. A long constrained-random mix of index rewrites, window accesses at every offset and stray region offsets is then compared access by access against a bench model. This exposes wrong routing, a lost or extra queue pop, and any strobe that is not one-hot.

// File: rtl/idxwin_pkg.sv
package idxwin_pkg;
  localparam int unsigned IDX_W   = 8;
  localparam int unsigned N_TGT   = 5;
  localparam int unsigned REGION_AW = 5;
  localparam int unsigned OFF_W   = 4;

  typedef enum logic [2:0] {
    TGT_CH1   = 3'd0,
    TGT_CH2   = 3'd1,
    TGT_LFIFO = 3'd2,
    TGT_BLO   = 3'd3,
    TGT_BHI   = 3'd4,
    TGT_NONE  = 3'd7
  } tgt_e;

  function automatic tgt_e decode_index(input logic [IDX_W-1:0] v);
    case (v)
      8'h00:   return TGT_CH1;
      8'h01:   return TGT_CH2;
      8'h02:   return TGT_LFIFO;
      8'h04:   return TGT_BLO;
      8'h06:   return TGT_BHI;
      default: return TGT_NONE;
    endcase
  endfunction
endpackage

// File: rtl/idxwin_index_reg.sv
module idxwin_index_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] idx_q
);
  logic [W-1:0] idx_d;

  always_comb begin
    idx_d = idx_q;
    if (wr_en) idx_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end
endmodule

// File: rtl/idxwin_fifo.sv
module idxwin_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = empty ? '0 : mem[rp_q];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + AW'(1);
  endfunction

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (do_push) wp_d = bump(wp_q);
    if (do_pop)  rp_d = bump(rp_q);
    case ({do_push, do_pop})
      2'b10:   cnt_d = cnt_q + CW'(1);
      2'b01:   cnt_d = cnt_q - CW'(1);
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= din;
  end
endmodule

// File: rtl/idxwin_chan_stub.sv
module idxwin_chan_stub #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stb,
  input  logic          wr,
  input  logic [3:0]    off,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam logic [3:0] OFF_DATA = 4'h0;
  localparam logic [3:0] OFF_CTRL = 4'h4;

  logic [DW-1:0] ctrl_q, ctrl_d;
  logic [DW-1:0] q_dout;
  logic          q_empty, q_full;
  logic          q_push, q_pop;

  assign q_push = stb && wr  && (off == OFF_DATA);
  assign q_pop  = stb && !wr && (off == OFF_DATA);

  idxwin_fifo #(.W(DW), .DEPTH(DEPTH)) u_q (
    .clk(clk), .rst_n(rst_n), .push(q_push), .pop(q_pop),
    .din(wdata), .dout(q_dout), .empty(q_empty), .full(q_full)
  );

  always_comb begin
    ctrl_d = ctrl_q;
    if (stb && wr && (off == OFF_CTRL)) ctrl_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  always_comb begin
    case (off)
      OFF_DATA: rdata = q_dout;
      OFF_CTRL: rdata = ctrl_q;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/idxwin_bank_stub.sv
module idxwin_bank_stub #(
  parameter int unsigned N_REG = 16,
  parameter int unsigned RW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stb,
  input  logic          wr,
  input  logic [3:0]    off,
  input  logic [RW-1:0] wdata,
  output logic [RW-1:0] rdata
);
  logic [RW-1:0] regs_q [N_REG];
  logic [RW-1:0] regs_d [N_REG];

  always_comb begin
    for (int i = 0; i < N_REG; i++) begin
      regs_d[i] = regs_q[i];
      if (stb && wr && (off == 4'(i))) regs_d[i] = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_REG; i++) regs_q[i] <= '0;
    end else begin
      for (int i = 0; i < N_REG; i++) regs_q[i] <= regs_d[i];
    end
  end

  assign rdata = regs_q[off];
endmodule

// File: rtl/idxwin_decoder.sv
module idxwin_decoder
  import idxwin_pkg::*;
#(
  parameter int unsigned CH_DEPTH = 4,
  parameter int unsigned LF_DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_en,
  input  logic        host_wr,
  input  logic [4:0]  host_addr,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  output logic [4:0]  tgt_stb,
  output logic [3:0]  tgt_off
);
  localparam logic [REGION_AW-1:0] IDX_ADDR = 5'h04;
  localparam int unsigned N_CH   = 2;
  localparam int unsigned N_BANK = 2;

  logic [IDX_W-1:0] idx_q;
  logic             idx_hit, win_hit;
  tgt_e             tgt;
  logic [31:0]      ch_rdata [N_CH];
  logic [7:0]       bank_rdata [N_BANK];
  logic [7:0]       lf_rdata;
  logic             lf_empty, lf_full;

  assign idx_hit = (host_addr == IDX_ADDR);
  assign win_hit = host_addr[REGION_AW-1];
  assign tgt_off = host_addr[OFF_W-1:0];
  assign tgt     = decode_index(idx_q);

  idxwin_index_reg #(.W(IDX_W)) u_idx (
    .clk(clk), .rst_n(rst_n),
    .wr_en(host_en && host_wr && idx_hit),
    .wdata(host_wdata[IDX_W-1:0]),
    .idx_q(idx_q)
  );

  always_comb begin
    tgt_stb = '0;
    if (host_en && win_hit && (tgt != TGT_NONE)) tgt_stb[tgt] = 1'b1;
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    idxwin_chan_stub #(.DW(32), .DEPTH(CH_DEPTH)) u_ch (
      .clk(clk), .rst_n(rst_n), .stb(tgt_stb[c]), .wr(host_wr),
      .off(tgt_off), .wdata(host_wdata), .rdata(ch_rdata[c])
    );
  end

  for (genvar b = 0; b < N_BANK; b++) begin : g_bank
    idxwin_bank_stub #(.N_REG(16), .RW(8)) u_bank (
      .clk(clk), .rst_n(rst_n), .stb(tgt_stb[int'(TGT_BLO) + b]), .wr(host_wr),
      .off(tgt_off), .wdata(host_wdata[7:0]), .rdata(bank_rdata[b])
    );
  end

  idxwin_fifo #(.W(8), .DEPTH(LF_DEPTH)) u_lfifo (
    .clk(clk), .rst_n(rst_n),
    .push(tgt_stb[TGT_LFIFO] && host_wr && (tgt_off == '0)),
    .pop(tgt_stb[TGT_LFIFO] && !host_wr && (tgt_off == '0)),
    .din(host_wdata[7:0]), .dout(lf_rdata), .empty(lf_empty), .full(lf_full)
  );

  always_comb begin
    host_rdata = '0;
    if (idx_hit) begin
      host_rdata = {24'h0, idx_q};
    end else if (win_hit) begin
      case (tgt)
        TGT_CH1:   host_rdata = ch_rdata[0];
        TGT_CH2:   host_rdata = ch_rdata[1];
        TGT_LFIFO: host_rdata = (tgt_off == '0) ? {24'h0, lf_rdata} : '0;
        TGT_BLO:   host_rdata = {24'h0, bank_rdata[0]};
        TGT_BHI:   host_rdata = {24'h0, bank_rdata[1]};
        default:   host_rdata = '1;
      endcase
    end
  end
endmodule

// File: rtl/idxwin_checker.sv
module idxwin_checker
  import idxwin_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        host_en,
  input logic        host_wr,
  input logic [4:0]  host_addr,
  input logic [31:0] host_rdata,
  input logic [4:0]  tgt_stb,
  input logic [3:0]  tgt_off,
  input logic [7:0]  idx_q
);
  logic win, defined;
  assign win     = host_en && host_addr[4];
  assign defined = (idx_q == 8'h00) || (idx_q == 8'h01) || (idx_q == 8'h02) ||
                   (idx_q == 8'h04) || (idx_q == 8'h06);

  assert_idx_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (host_en && !host_wr && host_addr == 5'h04) |-> host_rdata == {24'h0, idx_q});

  assert_idx_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_en && host_wr && host_addr == 5'h04) |=> $stable(idx_q));

  assert_undef_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (win && !host_wr && !defined) |-> host_rdata == 32'hFFFF_FFFF);

  assert_undef_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (win && !defined) |-> tgt_stb == '0);

  assert_single_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (win && defined) |-> $countones(tgt_stb) == 1);

  assert_idle_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !win |-> tgt_stb == '0);

  assert_strobe_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|tgt_stb) |-> tgt_off == host_addr[3:0]);

  assert_outside_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (host_en && !host_wr && !host_addr[4] && host_addr != 5'h04) |-> host_rdata == '0);
endmodule

bind idxwin_decoder idxwin_checker chk_i (
  .clk(clk), .rst_n(rst_n), .host_en(host_en), .host_wr(host_wr),
  .host_addr(host_addr), .host_rdata(host_rdata), .tgt_stb(tgt_stb),
  .tgt_off(tgt_off), .idx_q(idx_q)
);

// File: tb/idxwin_decoder_tb.sv
module idxwin_decoder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CH_DEPTH = 4;
  localparam int LF_DEPTH = 8;

  logic        clk, rst_n, host_en, host_wr;
  logic [4:0]  host_addr;
  logic [31:0] host_wdata, host_rdata;
  logic [4:0]  tgt_stb;
  logic [3:0]  tgt_off;

  int n_checks = 0;
  int n_errors = 0;

  idxwin_decoder #(.CH_DEPTH(CH_DEPTH), .LF_DEPTH(LF_DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .host_en(host_en), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .tgt_stb(tgt_stb), .tgt_off(tgt_off)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // bench model
  logic [7:0]  m_idx;
  logic [31:0] m_ctrl [2];
  logic [31:0] m_q0[$], m_q1[$];
  logic [7:0]  m_lq[$];
  logic [7:0]  m_bank [2][16];

  function automatic int m_tgt();
    case (m_idx)
      8'h00: return 0;
      8'h01: return 1;
      8'h02: return 2;
      8'h04: return 3;
      8'h06: return 4;
      default: return -1;
    endcase
  endfunction

  function automatic logic [31:0] exp_read(input logic [4:0] a);
    int t;
    logic [3:0] o;
    t = m_tgt();
    o = a[3:0];
    if (a == 5'h04) return {24'h0, m_idx};
    if (!a[4]) return 32'h0;
    case (t)
      0: return (o == 4'h0) ? ((m_q0.size() == 0) ? 32'h0 : m_q0[0]) : ((o == 4'h4) ? m_ctrl[0] : 32'h0);
      1: return (o == 4'h0) ? ((m_q1.size() == 0) ? 32'h0 : m_q1[0]) : ((o == 4'h4) ? m_ctrl[1] : 32'h0);
      2: return (o == 4'h0 && m_lq.size() != 0) ? {24'h0, m_lq[0]} : 32'h0;
      3: return {24'h0, m_bank[0][o]};
      4: return {24'h0, m_bank[1][o]};
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [4:0] exp_stb(input logic [4:0] a);
    int t;
    t = m_tgt();
    if (!a[4] || t < 0) return 5'h0;
    return 5'(1 << t);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_update(input logic wr, input logic [4:0] a, input logic [31:0] d);
    int t;
    logic [3:0] o;
    t = m_tgt();
    o = a[3:0];
    if (a == 5'h04) begin
      if (wr) m_idx = d[7:0];
    end else if (a[4]) begin
      case (t)
        0: if (o == 4'h0) begin
             if (wr) begin if (m_q0.size() < CH_DEPTH) m_q0.push_back(d); end
             else if (m_q0.size() != 0) void'(m_q0.pop_front());
           end else if (o == 4'h4 && wr) m_ctrl[0] = d;
        1: if (o == 4'h0) begin
             if (wr) begin if (m_q1.size() < CH_DEPTH) m_q1.push_back(d); end
             else if (m_q1.size() != 0) void'(m_q1.pop_front());
           end else if (o == 4'h4 && wr) m_ctrl[1] = d;
        2: if (o == 4'h0) begin
             if (wr) begin if (m_lq.size() < LF_DEPTH) m_lq.push_back(d[7:0]); end
             else if (m_lq.size() != 0) void'(m_lq.pop_front());
           end
        3: if (wr) m_bank[0][o] = d[7:0];
        4: if (wr) m_bank[1][o] = d[7:0];
        default: ;
      endcase
    end
  endtask

  // one access: drive at negedge, check mid-cycle, commits at next posedge
  task automatic access(input logic wr, input logic [4:0] a, input logic [31:0] d, input string req);
    logic [31:0] er;
    logic [4:0]  es;
    @(negedge clk);
    host_en = 1'b1; host_wr = wr; host_addr = a; host_wdata = d;
    er = exp_read(a);
    es = exp_stb(a);
    #1;
    if (!wr) check(req, host_rdata, er);
    check("R8 strobe", {27'h0, tgt_stb}, {27'h0, es});
    if (es != 5'h0) check("R8 offset", {28'h0, tgt_off}, {28'h0, a[3:0]});
    model_update(wr, a, d);
  endtask

  task automatic idle();
    @(negedge clk);
    host_en = 1'b0; host_wr = 1'b0;
    #1;
    check("R8 idle", {27'h0, tgt_stb}, 32'h0);
  endtask

  function automatic logic [4:0] lreg_addr(input logic [7:0] rn);
    return {1'b1, rn[3:0]};
  endfunction
  function automatic logic [7:0] lreg_bank(input logic [7:0] rn);
    return (rn > 8'h2F) ? 8'h06 : 8'h04;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    logic [4:0] a;
    logic [7:0] ivals [7];
    host_en = 0; host_wr = 0; host_addr = '0; host_wdata = '0;
    m_idx = 8'h00;
    m_ctrl[0] = '0; m_ctrl[1] = '0;
    for (int b = 0; b < 2; b++) for (int r = 0; r < 16; r++) m_bank[b][r] = 8'h00;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;

    // R1 reset value
    access(0, 5'h04, 0, "R1 reset index");
    // R9 outside offsets
    access(1, 5'h08, 32'hDEAD_BEEF, "R9");
    access(0, 5'h08, 0, "R9 read after write");
    access(0, 5'h00, 0, "R9 offset 0");
    access(0, 5'h04, 0, "R2 index after stray write");

    // R3 control words per channel
    access(1, 5'h14, 32'h1234_5678, "R3");
    access(1, 5'h04, 32'h0000_0001, "R2");
    access(1, 5'h14, 32'hABCD_EF01, "R3");
    access(0, 5'h14, 0, "R3 ch2 ctrl");
    access(1, 5'h04, 32'hFFFF_FF00, "R2");
    access(0, 5'h04, 0, "R2 index readback");
    access(0, 5'h14, 0, "R3 ch1 ctrl");

    // R4 channel queue order, overflow, underflow
    for (int i = 0; i < CH_DEPTH + 1; i++) access(1, 5'h10, 32'hC000_0000 + i, "R4");
    for (int i = 0; i < CH_DEPTH + 1; i++) access(0, 5'h10, 0, "R4 queue read");
    access(0, 5'h18, 0, "R4 other offset");

    // R5 line FIFO
    access(1, 5'h04, 32'h02, "R2");
    for (int i = 0; i < LF_DEPTH + 2; i++) access(1, 5'h10, 32'h5A5A_5A00 + i, "R5");
    access(0, 5'h13, 0, "R5 other offset");
    for (int i = 0; i < LF_DEPTH + 1; i++) access(0, 5'h10, 0, "R5 stream read");

    // R6 register-number mapping to banks
    access(1, 5'h04, {24'h0, lreg_bank(8'h35)}, "R6");
    access(1, lreg_addr(8'h35), 32'h77, "R6");
    access(1, 5'h04, {24'h0, lreg_bank(8'h25)}, "R6");
    access(1, lreg_addr(8'h25), 32'h33, "R6");
    access(0, lreg_addr(8'h25), 0, "R6 low bank");
    access(1, 5'h04, {24'h0, lreg_bank(8'h35)}, "R6");
    access(0, lreg_addr(8'h35), 0, "R6 high bank");

    // R7 undefined index
    access(1, 5'h04, 32'h03, "R7");
    access(1, 5'h15, 32'hEE, "R7 write ignored");
    access(0, 5'h15, 0, "R7 read all ones");
    access(1, 5'h04, 32'h06, "R7");
    access(0, 5'h15, 0, "R7 high bank untouched");
    access(1, 5'h04, 32'h04, "R7");
    access(0, 5'h15, 0, "R7 low bank untouched");
    idle();

    // constrained random
    void'($urandom(32'd20240611));
    ivals = '{8'h00, 8'h01, 8'h02, 8'h04, 8'h06, 8'h03, 8'hA5};
    for (int n = 0; n < 1500; n++) begin
      int r;
      r = int'($urandom_range(0, 99));
      if (r < 10) begin
        access(1, 5'h04, {24'h0, ivals[$urandom_range(0, 6)]}, "R2 random index");
      end else if (r < 15) begin
        a = 5'($urandom_range(0, 15));
        access(r[0], a, $urandom, "R9 random");
      end else if (r < 18) begin
        idle();
      end else begin
        a = {1'b1, ($urandom_range(0, 3) == 0) ? 4'h0 : (($urandom_range(0, 1) == 0) ? 4'h4 : 4'($urandom_range(0, 15)))};
        access($urandom_range(0, 1) == 1, a, $urandom, "R8 random window");
      end
    end
    access(0, 5'h04, 0, "R2 final index");
    idle();

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule